// File: doc/BRIEF.md
# AES-128 Word-Serial Encryptor

This block encrypts one 128-bit block under a 128-bit key with AES-128 while moving every 128-bit quantity over 32-bit ports. A block enters as four transfers; each transfer carries one plaintext word and the matching key word side by side. The core then runs the ten AES rounds on an internal 4x4 byte state, one 32-bit column per clock. Four shared byte-substitution units and one column mixer do all the work. The round keys are expanded on the fly, and the same four substitution units handle the key expansion in a dedicated cycle at the start of each round.

The input is a valid/ready stream. A word moves on every rising edge where `in_valid` and `in_ready` are both high. The source may insert idle cycles between words at will. While a block is being encrypted or emitted, `in_ready` is low and `in_valid` is ignored, so a source is back-pressured until the previous ciphertext has fully left.

The output has no back-pressure. The sink must take each word in the cycle its `out_valid` strobe is high. Column 0 is sent first on both sides, and within a word the most significant byte is row 0.

Top module: `aes128_wordserial`

## Requirements
- R1: While no block is in flight, `in_ready` is high; a word pair is taken on each edge with `in_valid` and `in_ready` high, the k-th taken pair being state column k (k = 0..3) with bits 31:24 holding row 0.
- R2: The four output words equal the AES-128 encryption of the taken plaintext under the taken key, column 0 first and row 0 in bits 31:24 (key 000102..0f with plaintext 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a).
- R3: `out_valid` is high for exactly four consecutive cycles, the first of them beginning 50 clock edges after the edge that took the fourth input word.
- R4: `busy` rises on the edge that takes the fourth input word and falls on the edge after the last output cycle; `in_ready` is its complement.
- R5: `in_valid`, `in_text` and `in_key` have no effect while `busy` is high.
- R6: Idle cycles between input words only delay the block; the words taken are those of the transfer cycles.
- R7: During and right after reset, `in_ready` is 1 and `busy`, `out_valid` and `out_data` are 0.
- R8: `out_data` is all zeros in every cycle where `out_valid` is low.
- R9: A new block can be taken in the cycle right after the last output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word pair is valid |
| in_ready | output | 1 | Core can take an input word pair |
| in_text | input | 32 | Plaintext column word |
| in_key | input | 32 | Key column word |
| busy | output | 1 | Block in flight (encrypting or emitting) |
| out_valid | output | 1 | Ciphertext word strobe |
| out_data | output | 32 | Ciphertext column word |

## Verification
The main function is exercised with the published example vector and with an all-zero key and plaintext. These two fix the byte and column ordering, the round-constant sequence and the last-round special case. Random key and plaintext blocks are then run against a behavioural reference built from a brute-force inverse table, which tells apart errors in the arithmetic substitution, the column mixing and the key step. Blocks are loaded with random idle gaps, back to back, and with junk `in_valid` asserted while busy. These runs separate correct handshake and timing from designs that drop, reorder or wrongly accept words.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int BYTE_W  = 8;
  localparam int NCOL    = 4;
  localparam int WORD_W  = BYTE_W * NCOL;
  localparam int NROUND  = 10;
  localparam int RND_W   = $clog2(NROUND + 1);
  localparam int COL_W   = $clog2(NCOL);
  localparam logic [BYTE_W-1:0] RCON_FIRST = 8'h01;

  typedef enum logic [1:0] {PH_LOAD, PH_KEY, PH_COL, PH_OUT} phase_t;

  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc, x;
    acc = '0;
    x   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = gf_dbl(x);
    end
    return acc;
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_pkg::*;
(
  input  logic [BYTE_W-1:0] x,
  output logic [BYTE_W-1:0] y
);
  logic [BYTE_W-1:0] inv, sq, b;

  // x^254 = product of x^(2^k) for k = 1..7; zero maps to zero
  always_comb begin
    sq  = gf_mul(x, x);
    inv = sq;
    for (int k = 2; k < BYTE_W; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
  end

  always_comb begin
    b = inv;
    y = b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
          ^ {b[3:0], b[7:4]} ^ 8'h63;
  end
endmodule

// File: rtl/aes_mixcol.sv
module aes_mixcol
  import aes_pkg::*;
(
  input  logic [WORD_W-1:0] col_in,
  output logic [WORD_W-1:0] col_out
);
  logic [BYTE_W-1:0] a [NCOL];
  logic [BYTE_W-1:0] d [NCOL];

  genvar r;
  generate
    for (r = 0; r < NCOL; r++) begin : g_row
      assign a[r] = col_in[WORD_W-1-BYTE_W*r -: BYTE_W];
      assign d[r] = gf_dbl(a[r]);
      // row r: 2*a[r] ^ 3*a[r+1] ^ a[r+2] ^ a[r+3]
      assign col_out[WORD_W-1-BYTE_W*r -: BYTE_W] =
        d[r] ^ d[(r+1)%NCOL] ^ a[(r+1)%NCOL] ^ a[(r+2)%NCOL] ^ a[(r+3)%NCOL];
    end
  endgenerate
endmodule

// File: rtl/aes_colpath.sv
module aes_colpath
  import aes_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] sub_out,
  output logic [WORD_W-1:0] mix_out
);
  genvar i;
  generate
    for (i = 0; i < NCOL; i++) begin : g_sb
      aes_sbox u_sb (
        .x (word_in[WORD_W-1-BYTE_W*i -: BYTE_W]),
        .y (sub_out[WORD_W-1-BYTE_W*i -: BYTE_W])
      );
    end
  endgenerate

  aes_mixcol u_mix (
    .col_in  (sub_out),
    .col_out (mix_out)
  );
endmodule

// File: rtl/aes128_wordserial.sv
module aes128_wordserial
  import aes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_text,
  input  logic [WORD_W-1:0] in_key,
  output logic              busy,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  phase_t                        phase;
  logic [COL_W-1:0]              cnt;
  logic [RND_W-1:0]              rnd;
  logic [BYTE_W-1:0]             rcon;
  logic [NCOL-1:0][WORD_W-1:0]   st, nx, rk, nk;
  logic [WORD_W-1:0]             gath, sel, sub_w, mix_w, res, kt;

  // ShiftRows gather: row r of column cnt comes from column cnt+r
  always_comb begin
    gath = '0;
    for (int r = 0; r < NCOL; r++) begin
      logic [COL_W-1:0] src;
      src = cnt + COL_W'(r);
      gath[WORD_W-1-BYTE_W*r -: BYTE_W] = st[src][WORD_W-1-BYTE_W*r -: BYTE_W];
    end
  end

  // key cycle borrows the substitution units for RotWord/SubWord
  assign sel = (phase == PH_KEY) ? {rk[NCOL-1][WORD_W-BYTE_W-1:0],
                                    rk[NCOL-1][WORD_W-1 -: BYTE_W]} : gath;

  aes_colpath u_path (
    .word_in (sel),
    .sub_out (sub_w),
    .mix_out (mix_w)
  );

  assign res = ((rnd == RND_W'(NROUND)) ? sub_w : mix_w) ^ rk[cnt];
  assign kt  = sub_w ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};

  always_comb begin
    nk[0] = rk[0] ^ kt;
    for (int c = 1; c < NCOL; c++) nk[c] = rk[c] ^ nk[c-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
      cnt   <= '0;
      rnd   <= '0;
      rcon  <= RCON_FIRST;
      st    <= '0;
      nx    <= '0;
      rk    <= '0;
    end else begin
      case (phase)
        PH_LOAD: if (in_valid) begin
          st[cnt] <= in_text ^ in_key;
          rk[cnt] <= in_key;
          cnt     <= cnt + 1'b1;
          if (cnt == COL_W'(NCOL-1)) begin
            phase <= PH_KEY;
            rnd   <= RND_W'(1);
            rcon  <= RCON_FIRST;
          end
        end
        PH_KEY: begin
          rk    <= nk;
          rcon  <= gf_dbl(rcon);
          phase <= PH_COL;
        end
        PH_COL: begin
          cnt <= cnt + 1'b1;
          if (cnt != COL_W'(NCOL-1)) begin
            nx[cnt] <= res;
          end else begin
            st <= {res, nx[2], nx[1], nx[0]};
            if (rnd == RND_W'(NROUND)) begin
              phase <= PH_OUT;
            end else begin
              rnd   <= rnd + 1'b1;
              phase <= PH_KEY;
            end
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == COL_W'(NCOL-1)) phase <= PH_LOAD;
        end
      endcase
    end
  end

  assign in_ready  = (phase == PH_LOAD);
  assign busy      = (phase != PH_LOAD);
  assign out_valid = (phase == PH_OUT);
  assign out_data  = out_valid ? st[cnt] : '0;

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  // R3
  out_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R3
  out_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> !busy);

  // R8
  out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

  // R5
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COL || phase == PH_OUT) |=> $stable(rk) || $past(phase == PH_OUT));

  // R2
  rcon_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_KEY) |-> (rcon != '0 && rnd != '0));
endmodule

// File: tb/tb_aes128_wordserial.sv
module tb_aes128_wordserial;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_text = 0;
  logic [31:0] in_key = 0;
  logic        busy;
  logic        out_valid;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  aes128_wordserial dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_text(in_text), .in_key(in_key), .busy(busy),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] sb [256];

  // model state
  int          phase = -1;
  logic [31:0] tq[$];
  logic [31:0] kq[$];
  logic [127:0] exp_ct;
  logic [127:0] cap;
  string       ctx = "R2";

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = (x << 1) ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
    logic [31:0] w [44];
    logic [7:0]  s [16];
    logic [7:0]  t [16];
    logic [7:0]  rc = 8'h01;
    logic [127:0] o;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] tw = w[i-1];
      if (i % 4 == 0) begin
        tw = subw({tw[23:0], tw[31:24]}) ^ {rc, 24'h0};
        rc = bmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ tw;
    end
    for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ k[127-8*i -: 8];
    for (int rn = 1; rn <= 10; rn++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[c*4+r] = s[((c+r)%4)*4+r];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          if (rn < 10)
            s[c*4+r] = bmul(t[c*4+r], 8'h02) ^ bmul(t[c*4+(r+1)%4], 8'h03)
                     ^ t[c*4+(r+2)%4] ^ t[c*4+(r+3)%4];
          else
            s[c*4+r] = t[c*4+r];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          s[c*4+r] ^= w[4*rn+c][31-8*r -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  // one clock: advance the model with the inputs held over the edge, compare
  task automatic tick();
    @(posedge clk);
    #2;
    if (phase < 0) begin
      if (in_valid) begin
        tq.push_back(in_text);
        kq.push_back(in_key);
        if (tq.size() == 4) begin
          exp_ct = ref_enc({kq[0], kq[1], kq[2], kq[3]}, {tq[0], tq[1], tq[2], tq[3]});
          tq.delete();
          kq.delete();
          phase = 0;
        end
      end
    end else begin
      phase++;
      if (phase == 54) phase = -1;
    end
    check(busy == (phase >= 0), "R4", 128'(busy), 128'(phase >= 0));
    check(in_ready == (phase < 0), "R1", 128'(in_ready), 128'(phase < 0));
    check(out_valid == (phase >= 50), "R3", 128'(out_valid), 128'(phase >= 50));
    if (phase >= 50) begin
      check(out_data == exp_ct[127-32*(phase-50) -: 32], ctx, 128'(out_data),
            128'(exp_ct[127-32*(phase-50) -: 32]));
      cap[127-32*(phase-50) -: 32] = out_data;
    end else begin
      check(out_data == 32'h0, "R8", 128'(out_data), 128'h0);
    end
  endtask

  task automatic send(input logic [127:0] k, input logic [127:0] p, input int gaps,
                      input bit junk);
    for (int i = 0; i < 4; i++) begin
      if (gaps > 0) begin
        int g = $urandom_range(gaps, 0);
        for (int j = 0; j < g; j++) begin
          in_valid = 0;
          in_text = $urandom;
          in_key = $urandom;
          tick();
        end
      end
      in_valid = 1;
      in_text = p[127-32*i -: 32];
      in_key = k[127-32*i -: 32];
      tick();
    end
    while (phase >= 0) begin
      in_valid = junk;
      in_text = $urandom;
      in_key = $urandom;
      tick();
    end
    in_valid = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 0;
      logic [7:0] y;
      for (int b = 1; b < 256; b++)
        if (bmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
             ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb[a] = y;
    end

    // R7: reset state
    #23;
    check(in_ready == 1 && busy == 0 && out_valid == 0 && out_data == 0, "R7",
          {in_ready, busy, out_valid, out_data}, {3'b100, 32'h0});
    @(negedge clk);
    rst_n = 1;
    #1;
    check(in_ready == 1 && busy == 0 && out_valid == 0 && out_data == 0, "R7",
          {in_ready, busy, out_valid, out_data}, {3'b100, 32'h0});

    // R2: published example vector
    ctx = "R2";
    send(128'h000102030405060708090a0b0c0d0e0f,
         128'h00112233445566778899aabbccddeeff, 0, 0);
    check(cap == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2", cap,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // R2: all-zero key and plaintext
    send(128'h0, 128'h0, 0, 0);
    check(cap == 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R2", cap,
          128'h66e94bd4ef8a2c3b884cfa59ca342b2e);

    // R6: gaps in the input stream
    ctx = "R6";
    for (int n = 0; n < 4; n++)
      send({$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, 3, 0);

    // R5: junk valid while busy
    ctx = "R5";
    for (int n = 0; n < 4; n++)
      send({$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, 0, 1);

    // R9: back-to-back blocks
    ctx = "R9";
    for (int n = 0; n < 6; n++)
      send({$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, 0, 0);

    for (int j = 0; j < 5; j++) tick();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule